// File: doc/BRIEF.md
# Up/Down Counter with Interrupt Cause Status

This block holds a 16-bit signed up/down count and reports through a status word why it last asked for service. Single-cycle count-up and count-down pulses move the count by one. Four events can raise a service request: the count wrapping past its top value, the count wrapping past its bottom value, the count arriving at or above a high threshold, and the count arriving at or below a low threshold. Each event is taken as an edge, so it fires once per crossing and not on every cycle while the condition holds. When two events happen in the same cycle, the one with the higher priority is the one recorded.

The status word keeps one cause flag per event, and at most one of these flags is set at a time. It also keeps a pending flag that the host clears with an acknowledge pulse when its service routine starts, a lost flag that shows a request was dropped because the previous one was still pending, and an enable flag that a configuration load sets. A configuration load writes the thresholds, the reload value, the starting count and the counting mode (up-only or bidirectional). A separate reload command puts the reload value back into the count and discards any pending or lost request.

Top module: `updown_irq_status`

## Requirements
- R1: In bidirectional mode (cfg_bidir_i=1 at the last configuration load) an up pulse adds 1 to acc_o and a down pulse subtracts 1. Both pulses together, or neither, leave acc_o unchanged. In up-only mode down pulses are ignored, so an up pulse adds 1 whether or not a down pulse comes with it.
- R2: An up step from +32767 wraps acc_o to -32768 and raises the overflow event. A down step from -32768 wraps acc_o to +32767 and raises the underflow event.
- R3: The cause flags are status_o[7] overflow, status_o[6] underflow, status_o[5] high threshold and status_o[4] low threshold. A recorded event sets its own flag and clears the other three, so no more than one of the four is ever 1.
- R4: Events in the same cycle are ranked overflow first, then underflow, then high threshold, then low threshold. Only the highest-ranked event sets its cause flag.
- R5: The high threshold event fires on a step that takes acc_o from below the high threshold to equal to or above it. The low threshold event fires on a step that takes acc_o from above the low threshold to equal to or below it, and only in bidirectional mode. Both comparisons are signed.
- R6: The pending flag status_o[3] is set by a recorded event and cleared by ack_i. An event in the same cycle as ack_i leaves it set. irq_o is 1 exactly when both pending and enable (status_o[1]) are 1.
- R7: The lost flag status_o[2] is set when an event is recorded while pending is 1 and ack_i is 0. lost_clr_i clears it, but a new loss in the same cycle wins over the clear.
- R8: reload_i loads the reload value into acc_o and clears pending and lost. It keeps the cause flags, counts nothing and raises no event.
- R9: cfg_load_i loads the count, the thresholds, the reload value and the mode. It sets enable, clears the cause, pending and lost flags, and sets status_o[8] to cfg_lp_i in bidirectional mode or to 0 in up-only mode. It overrides every other input in that cycle.
- R10: After each count step or reload, status_o[8] equals (acc_o <= low threshold) in bidirectional mode and 0 in up-only mode. Between such updates it holds its value.
- R11: After reset acc_o, status_o and irq_o are 0, enable is 0 and the mode is bidirectional. While enable is 0, events change neither the cause flags nor pending.
- R12: status_o[15:9] and status_o[0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Count-up pulse |
| dn_i | input | 1 | Count-down pulse |
| cfg_load_i | input | 1 | Configuration load strobe |
| cfg_bidir_i | input | 1 | Mode at load: 1 bidirectional, 0 up-only |
| cfg_acc_i | input | 16 | Starting count, signed |
| cfg_hi_i | input | 16 | High threshold, signed |
| cfg_lo_i | input | 16 | Low threshold, signed |
| cfg_pre_i | input | 16 | Reload value, signed |
| cfg_lp_i | input | 1 | Initial value of status_o[8] |
| ack_i | input | 1 | Service routine start; clears pending |
| reload_i | input | 1 | Reload the count; clears pending and lost |
| lost_clr_i | input | 1 | Clear the lost flag |
| acc_o | output | 16 | Current count, signed |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Service request |

## Verification
The bench drives the count across both wrap points with thresholds set at the extremes, so overflow and low threshold fire together and so do underflow and high threshold. A design with the wrong ranking records the lower-ranked cause, and one that does not clear the other flags shows two causes at once. It moves the count back and forth around each threshold and holds it there to catch a detector that fires on level and not on edge, which would keep the lost flag set. It lines up an acknowledge with a new event, and a lost-clear with a new loss, to catch the wrong winner in either case. It also checks the up-only mode, where ignored down pulses and a lost LP initial value would show up on acc_o and status_o[8].

// File: rtl/updown_irq_pkg.sv
package updown_irq_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned N_EVT  = 4;

  // event index doubles as priority rank (0 = highest)
  localparam int unsigned EV_OVF = 0;
  localparam int unsigned EV_UNF = 1;
  localparam int unsigned EV_HI  = 2;
  localparam int unsigned EV_LO  = 3;

  localparam int unsigned ST_LP   = 8;
  localparam int unsigned ST_OVF  = 7;
  localparam int unsigned ST_UNF  = 6;
  localparam int unsigned ST_HI   = 5;
  localparam int unsigned ST_LO   = 4;
  localparam int unsigned ST_PEND = 3;
  localparam int unsigned ST_LOST = 2;
  localparam int unsigned ST_EN   = 1;

  typedef struct packed {
    logic             lp;
    logic [N_EVT-1:0] cause;  // [EV_*]
    logic             pend;
    logic             lost;
    logic             en;
  } stat_t;
endpackage

// File: rtl/updown_acc.sv
module updown_acc
  import updown_irq_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             cfg_load_i,
  input  logic             cfg_bidir_i,
  input  logic [W-1:0]     cfg_acc_i,
  input  logic [W-1:0]     cfg_hi_i,
  input  logic [W-1:0]     cfg_lo_i,
  input  logic [W-1:0]     cfg_pre_i,
  input  logic             reload_i,
  output logic [W-1:0]     acc_o,
  output logic [N_EVT-1:0] evt_o,
  output logic             lp_upd_o,
  output logic             lp_val_o,
  output logic             bidir_o
);
  localparam logic signed [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] acc_q, hi_q, lo_q, pre_q, acc_nx;
  logic                bidir_q;
  logic                dn_eff, inc, dec, mv, quiet;
  logic [N_EVT-1:0]    evt_raw;

  always_comb begin
    dn_eff = dn_i & bidir_q;
    inc    = up_i & ~dn_eff;
    dec    = dn_eff & ~up_i;
    mv     = inc | dec;
    quiet  = cfg_load_i | reload_i;
    acc_nx = inc ? acc_q + 1'b1 : (dec ? acc_q - 1'b1 : acc_q);

    evt_raw         = '0;
    evt_raw[EV_OVF] = inc & (acc_q == ACC_MAX);
    evt_raw[EV_UNF] = dec & (acc_q == ACC_MIN);
    evt_raw[EV_HI]  = mv & (acc_q < hi_q) & (acc_nx >= hi_q);
    evt_raw[EV_LO]  = mv & bidir_q & (acc_q > lo_q) & (acc_nx <= lo_q);
    evt_o           = quiet ? '0 : evt_raw;

    lp_upd_o = ~cfg_load_i & (reload_i | mv);
    lp_val_o = reload_i ? (pre_q <= lo_q) : (acc_nx <= lo_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      pre_q   <= '0;
      bidir_q <= 1'b1;
    end else if (cfg_load_i) begin
      acc_q   <= cfg_acc_i;
      hi_q    <= cfg_hi_i;
      lo_q    <= cfg_lo_i;
      pre_q   <= cfg_pre_i;
      bidir_q <= cfg_bidir_i;
    end else if (reload_i) begin
      acc_q <= pre_q;
    end else begin
      acc_q <= acc_nx;
    end
  end

  assign acc_o   = acc_q;
  assign bidir_o = bidir_q;
endmodule

// File: rtl/updown_evt_arb.sv
module updown_evt_arb
  import updown_irq_pkg::*;
#(
  parameter int unsigned N = N_EVT
) (
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  // lowest index wins
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign grant_o[g]  = evt_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | evt_i[g];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/updown_irq_state.sv
module updown_irq_state
  import updown_irq_pkg::*;
#(
  parameter int unsigned SW = STAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] grant_i,
  input  logic             any_i,
  input  logic             ack_i,
  input  logic             reload_i,
  input  logic             lost_clr_i,
  input  logic             cfg_load_i,
  input  logic             cfg_lp_i,
  input  logic             cfg_bidir_i,
  input  logic             lp_upd_i,
  input  logic             lp_val_i,
  input  logic             bidir_i,
  output logic [SW-1:0]    status_o,
  output logic             irq_o
);
  stat_t st_q;
  logic  rec, lose;

  assign rec  = any_i & st_q.en;
  assign lose = rec & st_q.pend & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (cfg_load_i) begin
      st_q.en    <= 1'b1;
      st_q.cause <= '0;
      st_q.pend  <= 1'b0;
      st_q.lost  <= 1'b0;
      st_q.lp    <= cfg_lp_i & cfg_bidir_i;
    end else begin
      if (lp_upd_i) st_q.lp <= lp_val_i & bidir_i;
      if (reload_i) begin
        st_q.pend <= 1'b0;
        st_q.lost <= 1'b0;
      end else begin
        if (rec) st_q.cause <= grant_i;
        st_q.pend <= rec | (st_q.pend & ~ack_i);
        st_q.lost <= lose | (st_q.lost & ~lost_clr_i);
      end
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_LP]   = st_q.lp;
    status_o[ST_OVF]  = st_q.cause[EV_OVF];
    status_o[ST_UNF]  = st_q.cause[EV_UNF];
    status_o[ST_HI]   = st_q.cause[EV_HI];
    status_o[ST_LO]   = st_q.cause[EV_LO];
    status_o[ST_PEND] = st_q.pend;
    status_o[ST_LOST] = st_q.lost;
    status_o[ST_EN]   = st_q.en;
  end

  assign irq_o = st_q.pend & st_q.en;
endmodule

// File: rtl/updown_irq_status.sv
module updown_irq_status
  import updown_irq_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned SW = STAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          dn_i,
  input  logic          cfg_load_i,
  input  logic          cfg_bidir_i,
  input  logic [W-1:0]  cfg_acc_i,
  input  logic [W-1:0]  cfg_hi_i,
  input  logic [W-1:0]  cfg_lo_i,
  input  logic [W-1:0]  cfg_pre_i,
  input  logic          cfg_lp_i,
  input  logic          ack_i,
  input  logic          reload_i,
  input  logic          lost_clr_i,
  output logic [W-1:0]  acc_o,
  output logic [SW-1:0] status_o,
  output logic          irq_o
);
  logic [N_EVT-1:0] evt, grant;
  logic             any, lp_upd, lp_val, bidir;

  updown_acc #(.W(W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .up_i        (up_i),
    .dn_i        (dn_i),
    .cfg_load_i  (cfg_load_i),
    .cfg_bidir_i (cfg_bidir_i),
    .cfg_acc_i   (cfg_acc_i),
    .cfg_hi_i    (cfg_hi_i),
    .cfg_lo_i    (cfg_lo_i),
    .cfg_pre_i   (cfg_pre_i),
    .reload_i    (reload_i),
    .acc_o       (acc_o),
    .evt_o       (evt),
    .lp_upd_o    (lp_upd),
    .lp_val_o    (lp_val),
    .bidir_o     (bidir)
  );

  updown_evt_arb #(.N(N_EVT)) u_arb (
    .evt_i   (evt),
    .grant_o (grant),
    .any_o   (any)
  );

  updown_irq_state #(.SW(SW)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .any_i       (any),
    .ack_i       (ack_i),
    .reload_i    (reload_i),
    .lost_clr_i  (lost_clr_i),
    .cfg_load_i  (cfg_load_i),
    .cfg_lp_i    (cfg_lp_i),
    .cfg_bidir_i (cfg_bidir_i),
    .lp_upd_i    (lp_upd),
    .lp_val_i    (lp_val),
    .bidir_i     (bidir),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/updown_irq_status_chk.sv
module updown_irq_status_chk
  import updown_irq_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned SW = STAT_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          up_i,
  input logic          dn_i,
  input logic          cfg_load_i,
  input logic          reload_i,
  input logic [W-1:0]  acc_o,
  input logic [SW-1:0] status_o,
  input logic          irq_o
);
  localparam logic [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};

  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(status_o[ST_OVF:ST_LO])); // R3
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (acc_o == ACC_MAX && up_i && !dn_i && !reload_i && !cfg_load_i) |=> (acc_o == ACC_MIN)); // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> status_o[ST_EN]); // R6
  AST_LOST_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(status_o[ST_LOST]) |-> $past(status_o[ST_PEND])); // R7
  AST_RELOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (reload_i && !cfg_load_i) |=> (!status_o[ST_PEND] && !status_o[ST_LOST] && !irq_o)); // R8
endmodule

bind updown_irq_status updown_irq_status_chk #(.W(W), .SW(SW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_i       (up_i),
  .dn_i       (dn_i),
  .cfg_load_i (cfg_load_i),
  .reload_i   (reload_i),
  .acc_o      (acc_o),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/updown_irq_status_tb_top.sv
module updown_irq_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        up_i = 0, dn_i = 0, cfg_load_i = 0, cfg_bidir_i = 0, cfg_lp_i = 0;
  logic        ack_i = 0, reload_i = 0, lost_clr_i = 0;
  logic [15:0] cfg_acc_i = '0, cfg_hi_i = '0, cfg_lo_i = '0, cfg_pre_i = '0;
  logic [15:0] acc_o, status_o;
  logic        irq_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  updown_irq_status dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(up_i), .dn_i(dn_i),
    .cfg_load_i(cfg_load_i), .cfg_bidir_i(cfg_bidir_i), .cfg_acc_i(cfg_acc_i),
    .cfg_hi_i(cfg_hi_i), .cfg_lo_i(cfg_lo_i), .cfg_pre_i(cfg_pre_i), .cfg_lp_i(cfg_lp_i),
    .ack_i(ack_i), .reload_i(reload_i), .lost_clr_i(lost_clr_i),
    .acc_o(acc_o), .status_o(status_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";

  // reference model state
  int m_acc = 0, m_hi = 0, m_lo = 0, m_pre = 0;
  bit m_bidir = 1, m_en = 0, m_pend = 0, m_lost = 0, m_lp = 0;
  int m_cause = -1; // -1 none, 0 ovf, 1 unf, 2 hi, 3 lo

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    s[8] = m_lp;
    if (m_cause == 0) s[7] = 1'b1;
    if (m_cause == 1) s[6] = 1'b1;
    if (m_cause == 2) s[5] = 1'b1;
    if (m_cause == 3) s[4] = 1'b1;
    s[3] = m_pend;
    s[2] = m_lost;
    s[1] = m_en;
    return s;
  endfunction

  task automatic model_step();
    if (cfg_load_i) begin
      m_acc = sx(cfg_acc_i); m_hi = sx(cfg_hi_i); m_lo = sx(cfg_lo_i); m_pre = sx(cfg_pre_i);
      m_bidir = cfg_bidir_i; m_en = 1; m_cause = -1; m_pend = 0; m_lost = 0;
      m_lp = cfg_lp_i && cfg_bidir_i;
    end else if (reload_i) begin
      m_acc = m_pre; m_pend = 0; m_lost = 0;
      m_lp = m_bidir && (m_acc <= m_lo);
    end else begin
      bit d = m_bidir && dn_i;
      int stp = (up_i && !d) ? 1 : ((d && !up_i) ? -1 : 0);
      int old = m_acc;
      int nw = old + stp;
      int win = -1;
      bit lose = 0;
      if (nw > 32767) nw = -32768;
      if (nw < -32768) nw = 32767;
      if (stp != 0) begin
        if (m_bidir && old > m_lo && nw <= m_lo) win = 3;
        if (old < m_hi && nw >= m_hi) win = 2;
        if (stp == -1 && old == -32768) win = 1;
        if (stp == 1 && old == 32767) win = 0;
        m_lp = m_bidir && (nw <= m_lo);
      end
      if (win >= 0 && m_en) begin
        m_cause = win;
        lose = m_pend && !ack_i;
        m_pend = 1;
      end else if (ack_i) m_pend = 0;
      if (lose) m_lost = 1;
      else if (lost_clr_i) m_lost = 0;
      m_acc = nw;
    end
  endtask

  task automatic compare();
    logic [15:0] es = exp_status();
    bit ei = m_pend && m_en;
    n_chk++;
    if (sx(acc_o) != m_acc) begin
      n_fail++; $display("FAIL %s acc_o act=%0d exp=%0d", cur_req, sx(acc_o), m_acc);
    end
    n_chk++;
    if (status_o !== es) begin
      n_fail++; $display("FAIL %s status_o act=%h exp=%h", cur_req, status_o, es);
    end
    n_chk++;
    if (irq_o !== ei) begin
      n_fail++; $display("FAIL %s irq_o act=%b exp=%b", cur_req, irq_o, ei);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    {up_i, dn_i, cfg_load_i, ack_i, reload_i, lost_clr_i} = '0;
    compare();
  endtask

  task automatic cyc(input bit u, input bit d, input bit a = 0, input bit r = 0, input bit c = 0);
    up_i = u; dn_i = d; ack_i = a; reload_i = r; lost_clr_i = c;
    tick();
  endtask

  task automatic cfg(input bit bi, input int acc, input int hi, input int lo, input int pre, input bit lp);
    cfg_load_i = 1; cfg_bidir_i = bi; cfg_acc_i = acc[15:0]; cfg_hi_i = hi[15:0];
    cfg_lo_i = lo[15:0]; cfg_pre_i = pre[15:0]; cfg_lp_i = lp;
    tick();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired during %s", cur_req);
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R11 reset"; compare();
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11: events while enable=0 are not recorded
    cur_req = "R11 gated";
    repeat (3) cyc(1, 0);
    repeat (4) cyc(0, 1);
    cur_req = "R1 both"; cyc(1, 1);

    // R9: configure bidirectional, LP preset to 1
    cur_req = "R9 cfg"; cfg(1, 0, 10, -5, 100, 1);
    cur_req = "R10 hold"; cyc(0, 0);
    cur_req = "R5 hi";
    for (int i = 0; i < 10; i++) cyc(1, 0);
    cur_req = "R6 ack"; cyc(0, 0, 1);
    cur_req = "R5 once"; cyc(1, 0); cyc(1, 0);
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    cur_req = "R5 recross"; cyc(1, 0);
    cur_req = "R7 lost"; cyc(0, 1); cyc(1, 0);
    cur_req = "R7 clr"; cyc(0, 0, 0, 0, 1);
    cur_req = "R7 set wins"; cyc(0, 1); cyc(1, 0, 0, 0, 1);
    cur_req = "R6 ack+evt"; cyc(0, 1); cyc(1, 0, 1);
    cur_req = "R8 reload"; cyc(0, 0, 0, 1);
    cur_req = "R5 lo";
    cfg(1, 0, 10, -5, 100, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1);
    cur_req = "R10 lp"; cyc(1, 0); cyc(1, 0);
    cur_req = "R1 both"; cyc(1, 1);

    // R2/R4: wraps with thresholds at extremes
    cur_req = "R4 ovf>lo"; cfg(1, 32765, 32767, -32768, 0, 0);
    cyc(1, 0); cyc(1, 0, 1); cyc(0, 0, 1);
    cur_req = "R2 ovf"; cyc(1, 0);
    cyc(0, 0, 1);
    cur_req = "R4 unf>hi"; cyc(0, 1);
    cyc(0, 0, 1);
    cur_req = "R2 unf"; cyc(1, 0); cyc(0, 1);

    // R1/R10: up-only mode
    cur_req = "R9 upmode"; cfg(0, -2, 3, 0, 7, 1);
    cur_req = "R1 upmode";
    cyc(0, 1); cyc(1, 1); cyc(1, 0); cyc(0, 1); cyc(1, 0);
    cyc(1, 0); cyc(1, 0); cyc(1, 0);
    cur_req = "R8 reload"; cyc(0, 0, 0, 1);
    cur_req = "R12 reserved"; cyc(0, 0);

    // R3/R4/R6/R7/R10 mixed traffic
    cur_req = "R3 mixed";
    cfg(1, 0, 4, -3, 2, 0);
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 97) == 0) begin
        int hv = int'($urandom % 20) - 5;
        int lv = int'($urandom % 20) - 15;
        cfg($urandom % 4 != 0, int'($urandom % 30) - 15, hv, lv, int'($urandom % 30) - 15, $urandom % 2);
      end else begin
        cyc($urandom % 2, $urandom % 2, ($urandom % 6) == 0, ($urandom % 40) == 0, ($urandom % 9) == 0);
      end
    end
    cur_req = "R2 mixed";
    cfg(1, 32760, 32767, -32766, -32760, 0);
    for (int i = 0; i < 300; i++)
      cyc(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 60) == 0, ($urandom % 7) == 0);
    report();
  end
endmodule